// File: doc/BRIEF.md
# Receive Queue with Per-Character Line Status

This block buffers characters coming out of a serial receiver on their way to the processor. The deserializer reports each finished character as a byte plus its parity and framing flags, or reports a detected break. Every arrival becomes one 16-bit queue entry. The low byte holds the character, with bits above the programmed word length forced to zero. The high byte holds the error flags that belong to that character.

The flags ride along with their character. They reach the visible line-status register only when the entry becomes the head of the queue: either at once, when it lands in an empty queue, or when the processor reads the entry in front of it. Software therefore sees each error at the moment the faulty character is next to be read.

The queue depth is a parameter. It is 16 for a buffered port and 1 for a single-register port. When the queue is full, a further arrival is lost and an overrun is flagged. Every arrival also restarts the character-timeout logic elsewhere in the port.

Top module: `uart_rx_status_fifo`

## Requirements
- R1: The stored character keeps only its low 5 + `wlen_sel` bits and all higher bits read as zero. `wlen_sel` is sampled in the cycle the character arrives.
- R2: `lsr_out` bit positions are fixed. Bit 0 is data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break and bit 7 receiver error. Bits 5 and 6 are always 0. A character that arrives with a parity or framing flag carries that bit and bit 7 in its status byte.
- R3: An entry's status byte is ORed into `lsr_out` in the cycle after one of two events: the entry is written into an empty queue, or the entry in front of it is read. It has no effect before then.
- R4: `brk_vld` queues an entry with character 0x00 and status 0x91 (break, receiver error, data ready). If `char_vld` is high in the same cycle, the break is stored and the character is lost.
- R5: An arrival that finds the queue at full depth is discarded, even if a read happens in the same cycle. It sets overrun and receiver error in the next cycle.
- R6: Every arrival, stored or discarded, sets data ready and pulses `tmo_clr` high for exactly the next cycle.
- R7: A read that leaves entries in the queue keeps data ready set. A read of the only entry clears data ready, unless an arrival happens in the same cycle.
- R8: A read of an empty queue leaves `rd_data`, `lsr_out` and the queue contents unchanged.
- R9: The error bits (1, 2, 3, 4 and 7) stay set until `lsr_rd` is pulsed, and data reads do not clear them. An error set in the same cycle as `lsr_rd` survives it. `lsr_rd` does not change data ready.
- R10: A read and a stored arrival in the same cycle are both performed. The entry count is unchanged and the new entry keeps its place at the tail.
- R11: Entries are read in arrival order, and `rd_data` shows the read character from the cycle after `rbr_rd`. After reset, `lsr_out`, `rd_data` and `tmo_clr` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_vld | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | 8 | Received character |
| char_par_err | input | 1 | Parity error flag for the character |
| char_frm_err | input | 1 | Framing error flag for the character |
| brk_vld | input | 1 | One-cycle strobe: a break was detected |
| wlen_sel | input | 2 | Word length minus five |
| rbr_rd | input | 1 | Processor reads the receive data register |
| lsr_rd | input | 1 | Processor reads the line-status register |
| rd_data | output | 8 | Character returned by the last successful read |
| lsr_out | output | 8 | Line-status bits |
| tmo_clr | output | 1 | Restart pulse for the character-timeout counter |

## Verification
The properties assume that every strobe is a single-cycle pulse sampled on the rising edge. They also assume that `wlen_sel` is stable around each character arrival, so the masking seen at the read side matches the setting in force at arrival. The stimulus changes inputs only on the falling edge and holds every strobe for one cycle. It moves `wlen_sel` only between characters. It pulses `lsr_rd` only at chosen points, so the sticky-bit properties see long runs with no clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ST_DR  = 0;
  localparam int ST_OE  = 1;
  localparam int ST_PE  = 2;
  localparam int ST_FE  = 3;
  localparam int ST_BI  = 4;
  localparam int ST_RXE = 7;

  localparam logic [7:0] ERR_BITS = 8'h9E;

  typedef struct packed {
    logic [7:0] st;
    logic [7:0] ch;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_entry_fmt.sv
module rxq_entry_fmt
  import rxq_pkg::*;
(
  input  logic       char_vld,
  input  logic [7:0] char_data,
  input  logic       par_err,
  input  logic       frm_err,
  input  logic       brk_vld,
  input  logic [1:0] wlen_sel,
  output logic       arrive,
  output rxq_entry_t entry
);
  logic [7:0] keep_mask;

  always_comb begin
    keep_mask = 8'hFF >> (2'd3 - wlen_sel);
    arrive    = char_vld | brk_vld;
    entry     = '0;
    if (brk_vld) begin
      entry.ch         = 8'h00;
      entry.st[ST_BI]  = 1'b1;
      entry.st[ST_RXE] = 1'b1;
      entry.st[ST_DR]  = 1'b1;
    end else begin
      entry.ch         = char_data & keep_mask;
      entry.st[ST_PE]  = par_err;
      entry.st[ST_FE]  = frm_err;
      entry.st[ST_RXE] = par_err | frm_err;
    end
  end
endmodule

// File: rtl/rxq_storage.sv
module rxq_storage
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  rxq_entry_t    wr_entry,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          was_full,
  output logic          was_empty,
  output logic          was_one,
  output logic [7:0]    head_ch,
  output logic [7:0]    next_st,
  output logic [CW-1:0] occ
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] occ_q, occ_d;
  rxq_entry_t    mem_q [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign was_full  = (occ_q == CW'(DEPTH));
  assign was_empty = (occ_q == '0);
  assign was_one   = (occ_q == CW'(1));
  assign push_acc  = push_req & ~was_full;
  assign pop_acc   = pop_req & ~was_empty;
  assign occ       = occ_q;
  assign head_ch   = mem_q[rd_ptr_q].ch;
  assign next_st   = mem_q[bump(rd_ptr_q)].st;

  always_comb begin
    wr_ptr_d = push_acc ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_acc ? bump(rd_ptr_q) : rd_ptr_q;
    unique case ({push_acc, pop_acc})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (push_acc) wr_ptr_q <= wr_ptr_d;
      if (pop_acc) rd_ptr_q <= rd_ptr_d;
      if (push_acc ^ pop_acc) occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_acc) begin
      mem_q[wr_ptr_q] <= wr_entry;
    end
  end
endmodule

// File: rtl/rxq_lsr.sv
module rxq_lsr
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arrive,
  input  logic       drop,
  input  logic       push_acc,
  input  logic       pop_acc,
  input  logic       was_empty,
  input  logic       was_one,
  input  logic [7:0] new_st,
  input  logic [7:0] next_st,
  input  logic       lsr_rd,
  output logic [7:0] lsr,
  output logic       tmo_clr
);
  logic [7:0] merge;
  logic [7:0] err_q, err_d;
  logic       dr_q, dr_d;
  logic       tmo_q;

  always_comb begin
    merge = '0;
    if (push_acc && was_empty)
      merge = new_st;
    else if (pop_acc && !was_one)
      merge = next_st;
    else if (pop_acc && push_acc)
      merge = new_st;

    err_d = (lsr_rd ? 8'h00 : err_q) | (merge & ERR_BITS);
    if (drop) begin
      err_d[ST_OE]  = 1'b1;
      err_d[ST_RXE] = 1'b1;
    end

    dr_d = dr_q;
    if (arrive)
      dr_d = 1'b1;
    else if (pop_acc && was_one)
      dr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      dr_q  <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      err_q <= err_d;
      dr_q  <= dr_d;
      tmo_q <= arrive;
    end
  end

  assign lsr     = err_q | {7'b0, dr_q};
  assign tmo_clr = tmo_q;
endmodule

// File: rtl/uart_rx_status_fifo.sv
module uart_rx_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_vld,
  input  logic [7:0] char_data,
  input  logic       char_par_err,
  input  logic       char_frm_err,
  input  logic       brk_vld,
  input  logic [1:0] wlen_sel,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  output logic [7:0] rd_data,
  output logic [7:0] lsr_out,
  output logic       tmo_clr
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          arrive;
  rxq_entry_t    new_entry;
  logic          push_acc, pop_acc;
  logic          was_full, was_empty, was_one;
  logic [7:0]    head_ch, next_st;
  logic [CW-1:0] occ;
  logic [7:0]    rd_q;

  rxq_entry_fmt u_fmt (
    .char_vld  (char_vld),
    .char_data (char_data),
    .par_err   (char_par_err),
    .frm_err   (char_frm_err),
    .brk_vld   (brk_vld),
    .wlen_sel  (wlen_sel),
    .arrive    (arrive),
    .entry     (new_entry)
  );

  rxq_storage #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (arrive),
    .pop_req   (rbr_rd),
    .wr_entry  (new_entry),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .was_full  (was_full),
    .was_empty (was_empty),
    .was_one   (was_one),
    .head_ch   (head_ch),
    .next_st   (next_st),
    .occ       (occ)
  );

  rxq_lsr u_lsr (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive    (arrive),
    .drop      (arrive & was_full),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .was_empty (was_empty),
    .was_one   (was_one),
    .new_st    (new_entry.st),
    .next_st   (next_st),
    .lsr_rd    (lsr_rd),
    .lsr       (lsr_out),
    .tmo_clr   (tmo_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_q <= '0;
    else if (pop_acc)
      rd_q <= head_ch;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          char_vld,
  input logic          brk_vld,
  input logic          rbr_rd,
  input logic          lsr_rd,
  input logic [7:0]    rd_data,
  input logic [7:0]    lsr_out,
  input logic          tmo_clr,
  input logic [CW-1:0] occ
);
  logic arr;
  assign arr = char_vld | brk_vld;

  // R11
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R5
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr && occ == CW'(DEPTH)) |=> (lsr_out[1] && lsr_out[7]));

  // R6
  arrive_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr |=> (lsr_out[0] && tmo_clr));

  // R6
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arr |=> !tmo_clr);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && occ == '0 && !arr) |=> ($stable(rd_data) && occ == '0));

  // R7
  last_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && occ == CW'(1) && !arr) |=> !lsr_out[0]);

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_out[1] && !lsr_rd) |=> lsr_out[1]);

  // R10
  occ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr && rbr_rd && occ != '0 && occ != CW'(DEPTH)) |=> $stable(occ));

  // R2
  lsr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_out[6:5] == 2'b00);
endmodule

bind uart_rx_status_fifo rxq_chk #(.DEPTH(DEPTH)) u_rxq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .char_vld (char_vld),
  .brk_vld  (brk_vld),
  .rbr_rd   (rbr_rd),
  .lsr_rd   (lsr_rd),
  .rd_data  (rd_data),
  .lsr_out  (lsr_out),
  .tmo_clr  (tmo_clr),
  .occ      (occ)
);

// File: tb/tb_uart_rx_status_fifo.sv
module tb_uart_rx_status_fifo;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_vld = 1'b0;
  logic [7:0] char_data = '0;
  logic       char_par_err = 1'b0;
  logic       char_frm_err = 1'b0;
  logic       brk_vld = 1'b0;
  logic [1:0] wlen_sel = 2'd3;
  logic       rbr_rd = 1'b0;
  logic       lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] lsr_out;
  logic       tmo_clr;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] mq[$];
  logic [7:0]  m_err = '0;
  logic        m_dr = 1'b0;
  logic [7:0]  rd_exp_q[$];
  string       rd_tag_q[$];

  always #10 clk = ~clk;

  uart_rx_status_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_data(char_data),
    .char_par_err(char_par_err), .char_frm_err(char_frm_err), .brk_vld(brk_vld),
    .wlen_sel(wlen_sel), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .lsr_out(lsr_out), .tmo_clr(tmo_clr)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    while (rd_exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = rd_exp_q.pop_front();
      t = rd_tag_q.pop_front();
      check(rd_data == e, {t, " R11 rd_data"}, {8'h0, rd_data}, {8'h0, e});
    end
  end

  // driver: one cycle of stimulus, model update, then port checks
  task automatic cyc(input bit cv, input logic [7:0] cd, input bit pe, input bit fe,
                     input bit bk, input bit rd, input bit lr, input string tag);
    int          occ0;
    bit          arr, full, acc, pop;
    logic [15:0] ent;
    logic [7:0]  mask, merge, m_rd;
    char_vld = cv; char_data = cd; char_par_err = pe; char_frm_err = fe;
    brk_vld = bk; rbr_rd = rd; lsr_rd = lr;
    occ0 = mq.size();
    arr  = cv | bk;
    full = (occ0 == DEPTH);
    acc  = arr && !full;
    pop  = rd && (occ0 > 0);
    mask = 8'hFF >> (2'd3 - wlen_sel);
    if (bk) ent = {8'h91, 8'h00};
    else ent = {(pe ? 8'h04 : 8'h00) | (fe ? 8'h08 : 8'h00) | ((pe | fe) ? 8'h80 : 8'h00), cd & mask};
    merge = '0;
    m_rd = '0;
    if (pop) begin
      m_rd = mq[0][7:0];
      void'(mq.pop_front());
    end
    if (acc) mq.push_back(ent);
    if (acc && occ0 == 0) merge = ent[15:8];
    else if (pop && mq.size() > 0) merge = mq[0][15:8];
    m_err = (lr ? 8'h00 : m_err) | (merge & 8'h9E) | ((arr && full) ? 8'h82 : 8'h00);
    if (arr) m_dr = 1'b1;
    else if (pop && mq.size() == 0) m_dr = 1'b0;
    @(posedge clk);
    #1;
    if (pop) begin
      rd_exp_q.push_back(m_rd);
      rd_tag_q.push_back(tag);
    end
    @(negedge clk);
    char_vld = 1'b0; brk_vld = 1'b0; rbr_rd = 1'b0; lsr_rd = 1'b0;
    char_par_err = 1'b0; char_frm_err = 1'b0;
    check(lsr_out == (m_err | {7'b0, m_dr}), {tag, " lsr_out"}, {8'h0, lsr_out}, {8'h0, m_err | {7'b0, m_dr}});
    check(tmo_clr == arr, {tag, " R6 tmo_clr"}, {15'h0, tmo_clr}, {15'h0, arr});
  endtask

  task automatic push(input logic [7:0] d, input string tag);
    cyc(1, d, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic pull(input string tag);
    cyc(0, 8'h00, 0, 0, 0, 1, 0, tag);
  endtask

  task automatic clr(input string tag);
    cyc(0, 8'h00, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(lsr_out == 8'h00, "R11 reset lsr_out", {8'h0, lsr_out}, 16'h0);
    check(rd_data == 8'h00, "R11 reset rd_data", {8'h0, rd_data}, 16'h0);
    check(tmo_clr == 1'b0, "R11 reset tmo_clr", {15'h0, tmo_clr}, 16'h0);

    // R1 word-length masking for every setting
    for (int w = 0; w < 4; w++) begin
      wlen_sel = w[1:0];
      push(8'hFF, "R1 mask");
      pull("R1 mask read R7");
    end
    wlen_sel = 2'd3;

    // R2/R3 status stays with its character until it is at the head
    cyc(1, 8'hA5, 1, 0, 0, 0, 0, "R2 R3 parity into empty");
    cyc(1, 8'h3C, 0, 1, 0, 0, 0, "R3 framing behind head");
    clr("R9 clear keeps dr");
    pull("R3 framing reaches head");
    pull("R7 last read");
    clr("R9 clear");

    // R4 break entries, break wins over a simultaneous character
    cyc(0, 8'h00, 0, 0, 1, 0, 0, "R4 break");
    cyc(1, 8'h77, 0, 0, 1, 0, 0, "R4 break over char");
    pull("R4 break read");
    pull("R4 break read 2");
    clr("R9 clear after break");

    // R10 simultaneous read and write
    push(8'h11, "R10 prime");
    cyc(1, 8'h22, 0, 0, 0, 1, 0, "R10 swap clean");
    cyc(1, 8'h33, 1, 0, 0, 1, 0, "R10 R3 swap parity");
    pull("R10 drain");
    clr("R9 clear after swap");

    // R5/R6 overrun
    for (int i = 0; i < DEPTH; i++) push(8'h40 + i[7:0], "R11 fill");
    push(8'hEE, "R5 R6 drop");
    cyc(1, 8'h99, 0, 0, 0, 1, 0, "R5 drop with read");
    cyc(0, 8'h00, 0, 0, 0, 0, 0, "R9 sticky idle");
    push(8'h5A, "R11 refill");
    cyc(1, 8'h66, 0, 0, 0, 0, 1, "R9 set beats clear");
    clr("R9 clear overrun");
    for (int i = 0; i < DEPTH; i++) pull("R11 order drain R7");

    // R8 read while empty
    hold = rd_data;
    pull("R8 empty read");
    check(rd_data == hold, "R8 rd_data held", {8'h0, rd_data}, {8'h0, hold});
    cyc(0, 8'h00, 0, 0, 0, 0, 0, "R8 idle");
    push(8'hC3, "R8 after empty read");
    pull("R8 order kept");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule